// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers eighteen interrupt request lines and hands the CPU one vector index at a time. It latches each request on its rising edge into a pending flag. It presents the most urgent pending flag that software has unmasked. Sources are organised in six groups of three, and software gives each group one of four priority levels, so all three members of a group always compete at the same level.

The controller tracks which priority levels are currently being serviced. A new request interrupts a handler that is already running only when its level is strictly above every level in service. The CPU takes a presented vector with an acknowledge strobe and finishes a handler with a return strobe. Separately from the masking, a wake output tells the power logic that a source selected for wake-up is pending while the system sleeps.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: After reset, `irqValid` and `wakeOut` are 0, and every register reads back as 0.
- R2: A write with `regWr` high stores `regWdata` at the edge. The registers are:
  - address 0: per-source enable (bit s = source s).
  - address 1: group levels, with group g's 2-bit level in bits 2g+1:2g and bits above 11 reading 0.
  - address 2: per-source wake select.
  - address 3: global enable in bit 0, with the other bits reading 0.
  - `regRdata` shows the register chosen by `regAddr` in the same cycle.
- R3: A source's pending flag is set at the clock edge where its request is first seen high after being low. A request held high does not set it again after it has been cleared.
- R4: A pending source can be presented only while its enable bit and the global enable are both 1. A masked source keeps its pending flag, and it is presented once it is unmasked.
- R5: Source s belongs to group s mod 6 and takes that group's level. Level 3 is the most urgent. `irqVector` gives the pending, unmasked source with the highest level.
- R6: Among pending, unmasked sources of equal level, the lowest-numbered source is presented.
- R7: `irqAck` while `irqValid` is 1 clears the presented source's pending flag and places its level in service. `irqAck` while `irqValid` is 0 has no effect.
- R8: While levels are in service, a source is presented only if its level is strictly above the highest level in service. Sources at that level or below stay pending.
- R9: `irqRet` removes the highest level in service. It is ignored when nothing is in service. When `irqRet` and `irqAck` arrive in the same cycle, the acknowledge is ignored.
- R10: Handlers nest up to four deep, one for each level, and each level returns in turn.
- R11: `wakeOut` is 1 exactly when `sleepMode` is 1 and some source with its wake-select bit set is pending, whatever the enable bits say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 18 | Interrupt request lines, one per source |
| irqAck | input | 1 | CPU takes the presented vector |
| irqRet | input | 1 | CPU leaves the current handler |
| sleepMode | input | 1 | System is in a sleep state |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 18 | Register write data |
| regRdata | output | 18 | Register read data |
| irqValid | output | 1 | An interrupt is presented to the CPU |
| irqVector | output | 5 | Index of the presented source |
| wakeOut | output | 1 | Wake-up request to the power logic |

## Verification
The hardest state to reach is a full nest with all four levels in service, followed by a return and an acknowledge in the same cycle. To get there, the stimulus assigns group levels 0 to 3 to groups 0 to 3 and acknowledges one source from each group in rising order. It then parks a level-3 request behind the full nest, so that each return can be seen releasing or holding it. A long random phase then toggles requests, strobes and configuration writes, and a bench model checks the outputs every cycle.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  localparam int SRC_COUNT = 18;
  localparam int GRP_COUNT = 6;
  localparam int LVL_BITS  = 2;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_LEVEL  = 2'd1,
    SEL_WAKE   = 2'd2,
    SEL_CTRL   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ackTake;
    logic retTake;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpic_datapath.sv
module gpic_datapath
  import gpic_pkg::*;
#(
  parameter int NUM_SRC = SRC_COUNT,
  parameter int NUM_GRP = GRP_COUNT,
  parameter int PRI_W   = LVL_BITS,
  localparam int VEC_W  = $clog2(NUM_SRC),
  localparam int PRI_BITS = NUM_GRP * PRI_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               sleepMode,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] regWdata,
  output logic [NUM_SRC-1:0] regRdata,
  input  ctrlStrobe_t        strobe,
  output logic               bestValid,
  output logic [VEC_W-1:0]   bestVec,
  output logic [PRI_W-1:0]   bestLevel,
  output logic               wakeOut
);
  logic [NUM_SRC-1:0]  enMask;
  logic [NUM_SRC-1:0]  wakeMask;
  logic [PRI_BITS-1:0] grpLevel;
  logic                globalEn;
  logic [NUM_SRC-1:0]  pend;
  logic [NUM_SRC-1:0]  reqPrev;
  logic [NUM_SRC-1:0]  rise;
  logic [NUM_SRC-1:0]  cand;
  logic [NUM_SRC-1:0]  clrMask;
  logic [PRI_W-1:0]    srcLevel [NUM_SRC];

  // each source inherits the level of group (index mod group count)
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_srcLevel
    assign srcLevel[s] = grpLevel[(s % NUM_GRP)*PRI_W +: PRI_W];
  end

  assign rise = irqReq & ~reqPrev;
  assign cand = pend & enMask & {NUM_SRC{globalEn}};
  assign clrMask = strobe.ackTake ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << bestVec) : '0;

  // strictly-greater compare keeps the lower index on a tie
  always_comb begin
    bestValid = 1'b0;
    bestVec   = '0;
    bestLevel = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cand[s] && (!bestValid || srcLevel[s] > bestLevel)) begin
        bestValid = 1'b1;
        bestVec   = VEC_W'(s);
        bestLevel = srcLevel[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask   <= '0;
      wakeMask <= '0;
      grpLevel <= '0;
      globalEn <= 1'b0;
      pend     <= '0;
      reqPrev  <= '0;
    end else begin
      reqPrev <= irqReq;
      // a fresh edge wins over a clear of the same source
      pend    <= (pend & ~clrMask) | rise;
      if (regWr) begin
        unique case (regAddr)
          SEL_ENABLE: enMask   <= regWdata;
          SEL_LEVEL:  grpLevel <= regWdata[PRI_BITS-1:0];
          SEL_WAKE:   wakeMask <= regWdata;
          default:    globalEn <= regWdata[0];
        endcase
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      SEL_ENABLE: regRdata = enMask;
      SEL_LEVEL:  regRdata = {{(NUM_SRC-PRI_BITS){1'b0}}, grpLevel};
      SEL_WAKE:   regRdata = wakeMask;
      default:    regRdata = {{(NUM_SRC-1){1'b0}}, globalEn};
    endcase
  end

  assign wakeOut = sleepMode & (|(pend & wakeMask));

  AST_PEND_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (|rise) |=> ((pend & $past(rise)) == $past(rise))); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackTake |=> ((pend & $past(clrMask & ~rise)) == '0)); // R7
endmodule

// File: rtl/gpic_control.sv
module gpic_control
  import gpic_pkg::*;
#(
  parameter int PRI_W = LVL_BITS,
  localparam int NUM_LVL = 1 << PRI_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqAck,
  input  logic             irqRet,
  input  logic             bestValid,
  input  logic [PRI_W-1:0] bestLevel,
  output logic             irqValid,
  output ctrlStrobe_t      strobe
);
  // levels in service always nest strictly upward, so one bit per level holds the stack
  logic [NUM_LVL-1:0] activeMask;
  logic [PRI_W-1:0]   topLevel;
  logic               anyActive;
  logic [NUM_LVL-1:0] pushMask;
  logic [NUM_LVL-1:0] popMask;

  always_comb begin
    anyActive = |activeMask;
    topLevel  = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (activeMask[l]) topLevel = PRI_W'(l);
    end
  end

  assign irqValid       = bestValid && (!anyActive || bestLevel > topLevel);
  assign strobe.retTake = irqRet && anyActive;
  assign strobe.ackTake = irqAck && irqValid && !irqRet;

  assign pushMask = strobe.ackTake ? ({{(NUM_LVL-1){1'b0}}, 1'b1} << bestLevel) : '0;
  assign popMask  = strobe.retTake ? ({{(NUM_LVL-1){1'b0}}, 1'b1} << topLevel) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) activeMask <= '0;
    else       activeMask <= (activeMask & ~popMask) | pushMask;
  end

  AST_PUSH_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackTake |=> activeMask[$past(bestLevel)]); // R7
  AST_PUSH_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackTake |-> ((activeMask >> bestLevel) == '0)); // R8
  AST_RET_POP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retTake |=> ($countones(activeMask) == $countones($past(activeMask)) - 1)); // R9
  AST_RET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (irqRet && !anyActive && !irqAck) |=> (activeMask == '0)); // R9
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import gpic_pkg::*;
#(
  parameter int NUM_SRC = SRC_COUNT,
  parameter int NUM_GRP = GRP_COUNT,
  parameter int PRI_W   = LVL_BITS,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               irqAck,
  input  logic               irqRet,
  input  logic               sleepMode,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] regWdata,
  output logic [NUM_SRC-1:0] regRdata,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector,
  output logic               wakeOut
);
  ctrlStrobe_t      strobe;
  logic             bestValid;
  logic [PRI_W-1:0] bestLevel;

  gpic_datapath #(.NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .PRI_W(PRI_W)) u_dp (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .sleepMode(sleepMode),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .bestValid(bestValid), .bestVec(irqVector),
    .bestLevel(bestLevel), .wakeOut(wakeOut)
  );

  gpic_control #(.PRI_W(PRI_W)) u_ctl (
    .clk(clk), .rstN(rstN), .irqAck(irqAck), .irqRet(irqRet),
    .bestValid(bestValid), .bestLevel(bestLevel),
    .irqValid(irqValid), .strobe(strobe)
  );
endmodule

// File: tb/grouped_irq_ctrl_test.sv
`timescale 1ns/1ps
module grouped_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] req = '0;
  logic        ack = 1'b0, ret = 1'b0, sleep = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic        irqValid, wakeOut;
  logic [4:0]  irqVector;

  int checks = 0;
  int fails = 0;

  logic [17:0] mPend = '0, mEn = '0, mWm = '0, mPrev = '0;
  logic [11:0] mPri = '0;
  logic        mGen = 1'b0;
  logic [3:0]  mAct = '0;

  grouped_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .irqReq(req), .irqAck(ack), .irqRet(ret),
    .sleepMode(sleep), .regWr(wr), .regAddr(addr), .regWdata(wdata),
    .regRdata(rdata), .irqValid(irqValid), .irqVector(irqVector), .wakeOut(wakeOut)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void mSelect(output bit v, output int vec, output int lvl);
    v = 0; vec = 0; lvl = 0;
    for (int s = 0; s < 18; s++) begin
      if (mPend[s] && mEn[s] && mGen) begin
        int p = int'(mPri[(s % 6)*2 +: 2]);
        if (!v || p > lvl) begin v = 1; vec = s; lvl = p; end
      end
    end
  endfunction

  function automatic int mTop();
    for (int l = 3; l >= 0; l--) if (mAct[l]) return l;
    return -1;
  endfunction

  function automatic bit mPresent(output int vec, output int lvl);
    bit v;
    mSelect(v, vec, lvl);
    return v && (lvl > mTop());
  endfunction

  task automatic cycle(string tag);
    int pvec, plvl, evec, elvl, top;
    bit pres, eres;
    logic [17:0] rise;
    pres = mPresent(pvec, plvl);
    @(posedge clk);
    rise = req & ~mPrev;
    mPrev = req;
    if (wr) begin
      case (addr)
        2'd0: mEn = wdata;
        2'd1: mPri = wdata[11:0];
        2'd2: mWm = wdata;
        default: mGen = wdata[0];
      endcase
    end
    if (ret && mAct != 0) begin
      top = mTop();
      mAct[top] = 1'b0;
    end else if (ack && pres && !ret) begin
      mPend[pvec] = 1'b0;
      mAct[plvl] = 1'b1;
    end
    mPend = mPend | rise;
    @(negedge clk);
    ack = 0; ret = 0; wr = 0;
    #1;
    eres = mPresent(evec, elvl);
    chk({tag, " valid"}, irqValid, eres);
    if (eres) chk({tag, " vector"}, irqVector, evec);
    chk({tag, " wake"}, wakeOut, sleep && ((mPend & mWm) != 0));
  endtask

  task automatic wrReg(logic [1:0] a, logic [17:0] d, string tag);
    addr = a; wdata = d; wr = 1;
    cycle(tag);
  endtask

  task automatic rdChk(logic [1:0] a, logic [17:0] exp, string tag);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(int s, string tag);
    req[s] = 1'b1; cycle(tag);
    req[s] = 1'b0; cycle(tag);
  endtask

  task automatic doAck(string tag); ack = 1; cycle(tag); endtask
  task automatic doRet(string tag); ret = 1; cycle(tag); endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 valid", irqValid, 0);
    chk("R1 wake", wakeOut, 0);
    for (int a = 0; a < 4; a++) rdChk(2'(a), '0, "R1 readback");

    // R2 register port
    wrReg(2'd0, 18'h3FFFF, "R2");  rdChk(2'd0, 18'h3FFFF, "R2 enable");
    wrReg(2'd1, 18'h3FFFF, "R2");  rdChk(2'd1, 18'h00FFF, "R2 level");
    wrReg(2'd3, 18'h3FFFF, "R2");  rdChk(2'd3, 18'h00001, "R2 ctrl");
    wrReg(2'd2, 18'h0A5A5, "R2");  rdChk(2'd2, 18'h0A5A5, "R2 wake");
    wrReg(2'd2, 18'h0, "R2");
    wrReg(2'd1, 18'h1C, "R2");     // group1=3, group2=1
    wrReg(2'd3, 18'h0, "R2");

    // R4 masking
    pulse(4, "R4 global off");
    chk("R4 held by global", irqValid, 0);
    wrReg(2'd3, 18'h1, "R4");
    chk("R4 global on", irqVector, 4);
    wrReg(2'd0, 18'h3FFEF, "R4");
    chk("R4 source off", irqValid, 0);
    wrReg(2'd0, 18'h3FFFF, "R4");
    chk("R4 re-enabled", irqVector, 4);

    // R7 ack, then ack with nothing presented
    doAck("R7 take");
    chk("R7 cleared", irqValid, 0);
    doRet("R9 pop");
    doAck("R7 idle ack");

    // R3 held level does not retrigger
    req[5] = 1; cycle("R3 edge");
    chk("R3 latched", irqVector, 5);
    doAck("R3 ack");
    cycle("R3 held");
    chk("R3 no relatch", irqValid, 0);
    doRet("R3"); req[5] = 0; cycle("R3");

    // R5 group level
    req[2] = 1; req[13] = 1; cycle("R5");
    req[2] = 0; req[13] = 0; cycle("R5");
    chk("R5 highest group", irqVector, 13);
    // R8 equal-or-lower held
    doAck("R8");
    chk("R8 lower held", irqValid, 0);
    doRet("R8");
    chk("R8 released", irqVector, 2);
    doAck("R8"); doRet("R8");

    // R6 tie and equal level
    req[7] = 1; req[1] = 1; cycle("R6");
    req[7] = 0; req[1] = 0; cycle("R6");
    chk("R6 lowest index", irqVector, 1);
    doAck("R6");
    chk("R8 equal held", irqValid, 0);
    doRet("R6");
    chk("R6 second", irqVector, 7);
    doAck("R6"); doRet("R6");

    // R10 full nest
    wrReg(2'd1, 18'hE4, "R10");
    for (int g = 0; g < 4; g++) begin
      pulse(g, "R10 nest");
      chk("R10 presented", irqVector, g);
      doAck("R10 nest");
    end
    pulse(9, "R10 full");
    chk("R10 full held", irqValid, 0);
    doRet("R10 pop3");
    chk("R10 after pop", irqVector, 9);
    ack = 1; ret = 1; cycle("R9 both");
    chk("R9 ack dropped", irqVector, 9);
    doRet("R9"); doRet("R9");
    doRet("R9 extra");
    doRet("R9 empty");
    doAck("R9"); doRet("R9");

    // R11 wake
    wrReg(2'd0, 18'h07FFF, "R11");
    wrReg(2'd2, 18'h08000, "R11");
    sleep = 1;
    pulse(16, "R11 unselected");
    chk("R11 no wake", wakeOut, 0);
    pulse(15, "R11 selected");
    chk("R11 wake", wakeOut, 1);
    sleep = 0; #1;
    chk("R11 awake", wakeOut, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      req = req ^ (18'($urandom) & 18'($urandom) & 18'($urandom));
      ack = ($urandom % 100) < 30;
      ret = ($urandom % 100) < 12;
      sleep = ($urandom % 4) == 0;
      if (r < 4) begin addr = 2'd1; wdata = 18'($urandom); wr = 1; end
      else if (r < 7) begin addr = 2'd0; wdata = 18'($urandom) | 18'h2AAAA; wr = 1; end
      else if (r < 9) begin addr = 2'd2; wdata = 18'($urandom); wr = 1; end
      else if (r < 10) begin addr = 2'd3; wdata = 18'(($urandom % 4) != 0); wr = 1; end
      cycle("R5 R6 R8 R11 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule